// File: doc/BRIEF.md
# Two-Port Learning Bridge Forwarder

This block makes the forwarding decision of a two-port store-and-forward Ethernet bridge. It acts only once a frame has fully arrived and its checksum result is known. The receive path presents one descriptor per frame. The descriptor carries the destination and source MAC addresses, the ingress port (0 or 1) and a flag that says whether the frame check sequence was good. The block returns one decision: forward or drop. When it forwards, the egress port is always the port opposite the ingress port.

Inside, a small on-chip station table maps MAC addresses to ports. A controller serves the table through a request/response interface. For each good frame the controller first looks up the source address. It learns the source if it is new, or moves it if it has changed port. Only then does it look up the destination. Unknown destinations and group destinations are flooded to the other port. A destination learned on the ingress port is filtered. The table has `TBL_DEPTH` entries, and the design allows up to 8192. Once the table is full, new stations are no longer added, and forwarding carries on unchanged.

Top module: `bridge_fwd`

## Requirements
- R1: `frm_ready` is high while the block is idle and goes low in the cycle after a frame is accepted (`frm_valid` and `frm_ready` both high at a clock edge). Each accepted frame yields exactly one `dec_valid` pulse, one cycle wide, and `frm_ready` stays low until that pulse.
- R2: A frame whose `frm_fcs_ok` is 0 is always dropped (`dec_fwd`=0), and its source address is not learned.
- R3: A destination with the group bit set is forwarded to the other port. The group bit is bit 40 of the 48-bit address, which is bit 0 of the first octet in `[47:40]`.
- R4: A good frame whose unicast destination is not in the table is forwarded to the other port.
- R5: A good frame whose destination is in the table with the same port as the ingress port is dropped.
- R6: A good frame whose destination is in the table on the other port is forwarded. `dec_port` always equals the inverse of the ingress port.
- R7: The unicast source of a good frame that is not in the table is inserted with the ingress port, provided the table is not full.
- R8: A source address with the group bit set is never learned and uses no table entry.
- R9: A known source seen on the other port has its entry moved to the new ingress port.
- R10: When `TBL_DEPTH` entries are in use, a new source is not inserted, and its frames are still forwarded normally.
- R11: Learning the source finishes before the destination lookup of the same frame. A frame whose source equals its destination is therefore dropped.
- R12: Reset empties the table, sets `frm_ready` high and holds `dec_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | Frame descriptor present |
| frm_ready | output | 1 | Block can accept a descriptor |
| frm_dst | input | 48 | Destination MAC address |
| frm_src | input | 48 | Source MAC address |
| frm_port | input | 1 | Ingress port |
| frm_fcs_ok | input | 1 | Frame check sequence was good |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_fwd | output | 1 | 1 = forward, 0 = drop |
| dec_port | output | 1 | Egress port |

## Verification
The assertions assume that descriptor fields are stable whenever `frm_valid` is high. They also assume that the receive side offers a descriptor only through the valid/ready handshake. The stimulus meets both conditions: it waits for `frm_ready` at a falling edge, drives the descriptor for exactly one rising edge, and then releases `frm_valid`. It never issues a reset while a decision is outstanding, so no frame is lost mid-lookup. The station-table assertions also assume that every learn request comes from the controller. No stimulus reaches the table directly.

// File: rtl/bfw_pkg.sv
package bfw_pkg;

    typedef logic [47:0] mac_t;

    typedef enum logic [0:0] {
        TOP_LOOKUP = 1'b0,
        TOP_LEARN  = 1'b1
    } tbl_op_e;

    typedef struct packed {
        mac_t dst;
        mac_t src;
        logic port;
        logic fcs_ok;
    } frame_t;

    typedef struct packed {
        logic    valid;
        tbl_op_e op;
        mac_t    mac;
        logic    port;
    } tbl_req_t;

    typedef struct packed {
        logic valid;
        logic hit;
        logic port;
        logic full;
    } tbl_rsp_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SRC_REQ,
        ST_SRC_RSP,
        ST_LEARN,
        ST_DST_REQ,
        ST_DST_RSP
    } ctrl_state_e;

    function automatic logic mac_is_group(mac_t m);
        return m[40];
    endfunction

endpackage

// File: rtl/addr_table.sv
module addr_table
    import bfw_pkg::*;
#(
    parameter int TBL_DEPTH = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  tbl_req_t req,
    output tbl_rsp_t rsp
);
    localparam int IW = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1;
    localparam int CW = $clog2(TBL_DEPTH + 1);

    logic [TBL_DEPTH-1:0] ent_vld;
    mac_t                 ent_mac  [TBL_DEPTH];
    logic [TBL_DEPTH-1:0] ent_port;
    logic [CW-1:0]        used_cnt;

    logic [TBL_DEPTH-1:0] match;
    logic                 hit;
    logic                 hit_port;
    logic [IW-1:0]        hit_idx;
    logic                 is_full;

    for (genvar g = 0; g < TBL_DEPTH; g++) begin : g_cmp
        assign match[g] = ent_vld[g] && (ent_mac[g] == req.mac);
    end

    always_comb begin
        hit_port = 1'b0;
        hit_idx  = '0;
        for (int i = TBL_DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_port = ent_port[i];
                hit_idx  = IW'(i);
            end
        end
    end

    assign hit     = |match;
    assign is_full = (used_cnt == CW'(TBL_DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_vld  <= '0;
            ent_port <= '0;
            used_cnt <= '0;
            rsp      <= '0;
        end else begin
            rsp.valid <= req.valid && (req.op == TOP_LOOKUP);
            rsp.hit   <= hit;
            rsp.port  <= hit_port;
            rsp.full  <= is_full;
            if (req.valid && (req.op == TOP_LEARN)) begin
                if (hit) begin
                    ent_port[hit_idx] <= req.port;
                end else if (!is_full) begin
                    ent_vld[used_cnt[IW-1:0]]  <= 1'b1;
                    ent_mac[used_cnt[IW-1:0]]  <= req.mac;
                    ent_port[used_cnt[IW-1:0]] <= req.port;
                    used_cnt                   <= used_cnt + 1'b1;
                end
            end
        end
    end

    initial begin
        assert_depth_limit_R10: assert (TBL_DEPTH >= 1 && TBL_DEPTH <= 8192);
    end

    assert_count_bound_R10: assert property (@(posedge clk) disable iff (rst)
        used_cnt <= CW'(TBL_DEPTH));

    assert_insert_grows_R7: assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.op == TOP_LEARN && !hit && !is_full)
        |=> used_cnt == $past(used_cnt) + 1'b1);

    assert_full_no_insert_R10: assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.op == TOP_LEARN && is_full) |=> $stable(used_cnt));

    assert_onehot_match_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));

endmodule

// File: rtl/fwd_decide.sv
module fwd_decide
    import bfw_pkg::*;
(
    input  frame_t fr,
    input  logic   dst_hit,
    input  logic   dst_port,
    output logic   fwd,
    output logic   egress
);
    logic grp;
    logic same_seg;

    always_comb begin
        grp      = mac_is_group(fr.dst);
        same_seg = dst_hit && (dst_port == fr.port);
        egress   = ~fr.port;
        fwd      = fr.fcs_ok && (grp || !same_seg);
    end

endmodule

// File: rtl/bfw_ctrl.sv
module bfw_ctrl
    import bfw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     frm_valid,
    output logic     frm_ready,
    input  frame_t   frm_in,
    output frame_t   fr_q,
    output tbl_req_t tbl_req,
    input  tbl_rsp_t tbl_rsp,
    input  logic     fwd_in,
    input  logic     egress_in,
    output logic     dec_valid,
    output logic     dec_fwd,
    output logic     dec_port
);
    ctrl_state_e st;
    logic        learn_need;

    assign frm_ready = (st == ST_IDLE);

    always_comb begin
        learn_need = 1'b0;
        if (fr_q.fcs_ok && !mac_is_group(fr_q.src)) begin
            learn_need = tbl_rsp.hit ? (tbl_rsp.port != fr_q.port) : !tbl_rsp.full;
        end
    end

    always_comb begin
        tbl_req = '0;
        case (st)
            ST_SRC_REQ: begin
                tbl_req.valid = 1'b1;
                tbl_req.op    = TOP_LOOKUP;
                tbl_req.mac   = fr_q.src;
            end
            ST_LEARN: begin
                tbl_req.valid = 1'b1;
                tbl_req.op    = TOP_LEARN;
                tbl_req.mac   = fr_q.src;
                tbl_req.port  = fr_q.port;
            end
            ST_DST_REQ: begin
                tbl_req.valid = 1'b1;
                tbl_req.op    = TOP_LOOKUP;
                tbl_req.mac   = fr_q.dst;
            end
            default: tbl_req = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            fr_q      <= '0;
            dec_valid <= 1'b0;
            dec_fwd   <= 1'b0;
            dec_port  <= 1'b0;
        end else begin
            dec_valid <= 1'b0;
            case (st)
                ST_IDLE: if (frm_valid) begin
                    fr_q <= frm_in;
                    st   <= ST_SRC_REQ;
                end
                ST_SRC_REQ: st <= ST_SRC_RSP;
                ST_SRC_RSP: st <= learn_need ? ST_LEARN : ST_DST_REQ;
                ST_LEARN:   st <= ST_DST_REQ;
                ST_DST_REQ: st <= ST_DST_RSP;
                ST_DST_RSP: begin
                    dec_valid <= 1'b1;
                    dec_fwd   <= fwd_in;
                    dec_port  <= egress_in;
                    st        <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assert_accept_busy_R1: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && frm_ready) |=> !frm_ready);

    assert_single_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        dec_valid |=> !dec_valid);

    assert_learn_gated_R2: assert property (@(posedge clk) disable iff (rst)
        (tbl_req.valid && tbl_req.op == TOP_LEARN) |-> fr_q.fcs_ok);

    assert_no_group_learn_R8: assert property (@(posedge clk) disable iff (rst)
        (tbl_req.valid && tbl_req.op == TOP_LEARN) |-> !mac_is_group(fr_q.src));

    assert_bad_fcs_drop_R2: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !fr_q.fcs_ok) |-> !dec_fwd);

endmodule

// File: rtl/bridge_fwd.sv
module bridge_fwd
    import bfw_pkg::*;
#(
    parameter int TBL_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        frm_valid,
    output logic        frm_ready,
    input  logic [47:0] frm_dst,
    input  logic [47:0] frm_src,
    input  logic        frm_port,
    input  logic        frm_fcs_ok,
    output logic        dec_valid,
    output logic        dec_fwd,
    output logic        dec_port
);
    frame_t   frm_in;
    frame_t   fr_q;
    tbl_req_t tbl_req;
    tbl_rsp_t tbl_rsp;
    logic     fwd_c;
    logic     egress_c;

    assign frm_in = '{dst: frm_dst, src: frm_src, port: frm_port, fcs_ok: frm_fcs_ok};

    bfw_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .frm_valid (frm_valid),
        .frm_ready (frm_ready),
        .frm_in    (frm_in),
        .fr_q      (fr_q),
        .tbl_req   (tbl_req),
        .tbl_rsp   (tbl_rsp),
        .fwd_in    (fwd_c),
        .egress_in (egress_c),
        .dec_valid (dec_valid),
        .dec_fwd   (dec_fwd),
        .dec_port  (dec_port)
    );

    addr_table #(.TBL_DEPTH(TBL_DEPTH)) u_table (
        .clk (clk),
        .rst (rst),
        .req (tbl_req),
        .rsp (tbl_rsp)
    );

    fwd_decide u_decide (
        .fr       (fr_q),
        .dst_hit  (tbl_rsp.hit),
        .dst_port (tbl_rsp.port),
        .fwd      (fwd_c),
        .egress   (egress_c)
    );

    assert_egress_opposite_R6: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> (dec_port != fr_q.port));

    assert_group_flood_R3: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && fr_q.fcs_ok && mac_is_group(fr_q.dst)) |-> dec_fwd);

endmodule

// File: tb/bridge_fwd_tb_top.sv
module bridge_fwd_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frm_valid = 1'b0;
    logic        frm_ready;
    logic [47:0] frm_dst = '0;
    logic [47:0] frm_src = '0;
    logic        frm_port = 1'b0;
    logic        frm_fcs_ok = 1'b0;
    logic        dec_valid;
    logic        dec_fwd;
    logic        dec_port;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit prev_dv = 1'b0;
    bit done = 1'b0;

    typedef struct {
        bit    fwd;
        bit    port;
        string req;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    bridge_fwd #(.TBL_DEPTH(8)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .frm_valid  (frm_valid),
        .frm_ready  (frm_ready),
        .frm_dst    (frm_dst),
        .frm_src    (frm_src),
        .frm_port   (frm_port),
        .frm_fcs_ok (frm_fcs_ok),
        .dec_valid  (dec_valid),
        .dec_fwd    (dec_fwd),
        .dec_port   (dec_port)
    );

    function automatic logic [47:0] uc(int n);
        return 48'h0200_0000_0000 | 48'(n);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic send(logic [47:0] d, logic [47:0] s, bit p, bit fcs, bit efwd, string req);
        exp_t e;
        while (!frm_ready) @(negedge clk);
        e.fwd = efwd;
        e.port = ~p;
        e.req = req;
        sb.push_back(e);
        frm_dst = d;
        frm_src = s;
        frm_port = p;
        frm_fcs_ok = fcs;
        frm_valid = 1'b1;
        @(negedge clk);
        frm_valid = 1'b0;
        check(frm_ready == 1'b0, "R1", "ready after accept", frm_ready, 0);
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (dec_valid && prev_dv)
                check(1'b0, "R1", "pulse wider than one cycle", 1, 0);
            if (dec_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R1", "unexpected decision", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(dec_fwd == e.fwd, e.req, "dec_fwd", dec_fwd, e.fwd);
                    check(dec_port == e.port, "R6", "dec_port", dec_port, e.port);
                end
            end
            prev_dv = dec_valid;
        end else begin
            prev_dv = 1'b0;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(frm_ready == 1'b1, "R12", "ready after reset", frm_ready, 1);
        check(dec_valid == 1'b0, "R12", "dec_valid after reset", dec_valid, 0);

        send(uc(1), uc(2), 0, 1, 1, "R4");                // unknown dst flood; learn 2@0
        send(uc(2), uc(3), 1, 1, 1, "R7");                // 2 on port0 -> fwd; learn 3@1
        send(uc(2), uc(4), 0, 1, 0, "R5");                // 2 on same port -> drop; learn 4@0
        send(48'hFFFF_FFFF_FFFF, uc(5), 0, 1, 1, "R3");   // broadcast; learn 5@0
        send(uc(6), uc(6), 1, 1, 0, "R11");               // self addressed -> drop; learn 6@1
        send(uc(3), uc(7), 0, 0, 0, "R2");                // bad FCS drop; 7 not learned
        send(uc(7), uc(8), 1, 1, 1, "R2");                // 7 still unknown -> flood; learn 8@1
        send(uc(1), 48'h0100_5E00_0001, 0, 1, 1, "R8");   // group source, not learned
        send(uc(9), uc(2), 1, 1, 1, "R4");                // 2 moves to port1
        send(uc(2), uc(3), 0, 1, 1, "R9");                // 2 now on port1 -> fwd
        send(uc(1), uc(10), 0, 1, 1, "R7");               // learn 10@0 (7 used)
        send(uc(1), uc(11), 0, 1, 1, "R7");               // learn 11@0 (8 used, full)
        send(uc(11), uc(12), 0, 1, 0, "R8");              // 11 learned (group src took no slot)
        send(uc(12), uc(4), 1, 1, 1, "R10");              // 12 not learned while full
        drain();

        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(frm_ready == 1'b1, "R12", "ready after second reset", frm_ready, 1);
        send(uc(4), uc(20), 1, 1, 1, "R12");              // 4 was on port1, now forgotten
        drain();

        check(sb.size() == 0, "R1", "outstanding decisions", sb.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule